// File: doc/BRIEF.md
# Multiplexed GPIO Port with Edge Interrupts

This block controls a bank of general-purpose pins (twelve by default). Each pin can serve as a plain software-controlled input or output, or it can be handed to one of two dedicated on-chip functions, called function A and function B. A small register file on a simple synchronous bus holds the per-pin configuration. The block drives the pad output value and the pad output enable for every pin. It also produces the input seen by each dedicated function and by an auxiliary sense input. Any of these inputs that is not connected to a pin is held at a fixed tie-off level.

The pin levels pass through a two-flop synchronizer before they reach software. Each synchronized pin feeds an edge detector that can be set to fire on any edge or on falling edges only. A detected edge sets a sticky event bit. Software clears an event bit by writing 1 to it. A single interrupt request is raised while any event bit is set and the matching mask bit is enabled.

Register map (3-bit word address, one bit per pin in each register): 0 assign, 1 direction, 2 option, 3 data, 4 edge-select, 5 mask, 6 event. Address 7 reads as zero.

Top module: `pinmux_port`

## Requirements
- R1: After reset, the assign, direction, mask and event registers read 0, every `pin_oe` bit is 0 and `irq` is 0.
- R2: A write to the data register always updates the output latch. When assign=0 and direction=1, `pin_o` shows the latch and `pin_oe` is 1. When assign=0 and direction=0, `pin_oe` is 0 and `pin_o` is 0.
- R3: A read of the data register returns the pin level after two clock edges of synchronization, not the latch contents, whatever the direction of the pin.
- R4: When assign=1 and direction=0, the pin's `pin_o`/`pin_oe` follow `fa_o`/`fa_oe`. When assign=1 and direction=1, they follow `fb_o`/`fb_oe`.
- R5: `fa_in[i]` equals `pin_i[i]` when assign=1 and direction=0, and otherwise equals `TIE_A[i]` (default 12'h0C3). `fb_in[i]` equals `pin_i[i]` when assign=1 and direction=1, and otherwise equals `TIE_B[i]` (default 12'hF00).
- R6: `alt_in[i]` equals `pin_i[i]` when option=1 and direction=0, and otherwise equals `TIE_S[i]` (default 12'h00F), independent of assign.
- R7: With edge-select bit 0, either edge of the synchronized pin sets its event bit. With edge-select bit 1, only a falling edge sets it, and a rising edge leaves it at 0.
- R8: Event bits are sticky. Writing 1 to an event bit clears it, and writing 0 leaves it unchanged.
- R9: `irq` is 1 exactly when some event bit and the matching mask bit are both 1.
- R10: After reset, pins held at a static level (including high) set no event bit.
- R11: The assign, direction, option, edge-select and mask registers read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | N | Write data, one bit per pin |
| bus_rdata | output | N | Read data for `bus_addr` (combinational) |
| pin_i | input | N | Level at each pad |
| pin_o | output | N | Value driven to each pad |
| pin_oe | output | N | Pad output enable |
| fa_o | input | N | Function A output value per pin |
| fa_oe | input | N | Function A output enable per pin |
| fb_o | input | N | Function B output value per pin |
| fb_oe | input | N | Function B output enable per pin |
| fa_in | output | N | Input seen by function A |
| fb_in | output | N | Input seen by function B |
| alt_in | output | N | Auxiliary sense input seen by a peripheral |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situation to reach is a pin that already sits high when reset is released. A careless design reads this as a rising edge and sets a false event. To reach it, the bench drives the pins to a mixed static pattern before reset is lifted, waits, and reads the event register. A second hard case is the falling-only edge mode, which must ignore the rising half of a pulse. The bench walks one pin down and then back up, clearing the event between the two steps, so that each half is judged on its own. The multiplexing is covered by random assign, direction and option settings with random peripheral drive, and each of these is checked against a model in the bench.

// File: rtl/pmx_pkg.sv
package pmx_pkg;
  localparam int PMX_AW = 3;

  typedef enum logic [PMX_AW-1:0] {
    RA_ASSIGN = 3'd0,
    RA_DIR    = 3'd1,
    RA_OPT    = 3'd2,
    RA_DATA   = 3'd3,
    RA_EDGE   = 3'd4,
    RA_MASK   = 3'd5,
    RA_EVENT  = 3'd6,
    RA_NONE   = 3'd7
  } pmx_addr_e;
endpackage

// File: rtl/pmx_sync_edge.sv
module pmx_sync_edge #(
  parameter int N      = 12,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] edg_q,
  output logic [N-1:0] pin_sync,
  output logic [N-1:0] edge_hit
);
  localparam int CW      = $clog2(STAGES + 2);
  localparam int ARM_CNT = STAGES + 1;

  logic [CW-1:0] arm_q, arm_d;
  logic          armed;
  logic [N-1:0]  prev_q;

  // Edges are ignored until the synchronizer and the history flop hold real pin data.
  assign armed = (arm_q == CW'(ARM_CNT));

  always_comb begin
    arm_d = armed ? arm_q : arm_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_d;
  end

  for (genvar i = 0; i < N; i++) begin : g_pin
    logic [STAGES-1:0] sh_q, sh_d;
    logic              cur;

    always_comb begin
      sh_d = {sh_q[STAGES-2:0], pin_i[i]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_q      <= '0;
        prev_q[i] <= 1'b0;
      end else begin
        sh_q      <= sh_d;
        prev_q[i] <= sh_q[STAGES-1];
      end
    end

    assign cur         = sh_q[STAGES-1];
    assign pin_sync[i] = cur;
    assign edge_hit[i] = armed & (edg_q[i] ? (prev_q[i] & ~cur) : (prev_q[i] ^ cur));
  end
endmodule

// File: rtl/pmx_regfile.sv
module pmx_regfile
  import pmx_pkg::*;
#(
  parameter int N = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [PMX_AW-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pin_sync,
  input  logic [N-1:0]      edge_hit,
  output logic [N-1:0]      asg_q,
  output logic [N-1:0]      dir_q,
  output logic [N-1:0]      opt_q,
  output logic [N-1:0]      lat_q,
  output logic [N-1:0]      edg_q,
  output logic [N-1:0]      msk_q,
  output logic [N-1:0]      evt_q,
  output logic              irq
);
  logic [N-1:0] asg_d, dir_d, opt_d, lat_d, edg_d, msk_d, evt_d, clr;
  logic         wen;
  pmx_addr_e    ra;

  assign ra  = pmx_addr_e'(bus_addr);
  assign wen = bus_sel & bus_wr;

  always_comb begin
    asg_d = asg_q;
    dir_d = dir_q;
    opt_d = opt_q;
    lat_d = lat_q;
    edg_d = edg_q;
    msk_d = msk_q;
    clr   = '0;
    if (wen) begin
      case (ra)
        RA_ASSIGN: asg_d = bus_wdata;
        RA_DIR:    dir_d = bus_wdata;
        RA_OPT:    opt_d = bus_wdata;
        RA_DATA:   lat_d = bus_wdata;
        RA_EDGE:   edg_d = bus_wdata;
        RA_MASK:   msk_d = bus_wdata;
        RA_EVENT:  clr   = bus_wdata;
        default:   ;
      endcase
    end
    // A new edge in the same cycle as a clear keeps the bit set.
    evt_d = (evt_q & ~clr) | edge_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asg_q <= '0;
      dir_q <= '0;
      opt_q <= '0;
      lat_q <= '0;
      edg_q <= '0;
      msk_q <= '0;
      evt_q <= '0;
    end else begin
      asg_q <= asg_d;
      dir_q <= dir_d;
      opt_q <= opt_d;
      lat_q <= lat_d;
      edg_q <= edg_d;
      msk_q <= msk_d;
      evt_q <= evt_d;
    end
  end

  always_comb begin
    case (ra)
      RA_ASSIGN: bus_rdata = asg_q;
      RA_DIR:    bus_rdata = dir_q;
      RA_OPT:    bus_rdata = opt_q;
      RA_DATA:   bus_rdata = pin_sync;
      RA_EDGE:   bus_rdata = edg_q;
      RA_MASK:   bus_rdata = msk_q;
      RA_EVENT:  bus_rdata = evt_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq = |(evt_q & msk_q);
endmodule

// File: rtl/pmx_route.sv
module pmx_route #(
  parameter int         N     = 12,
  parameter logic [N-1:0] TIE_A = 12'h0C3,
  parameter logic [N-1:0] TIE_B = 12'hF00,
  parameter logic [N-1:0] TIE_S = 12'h00F
) (
  input  logic [N-1:0] asg_q,
  input  logic [N-1:0] dir_q,
  input  logic [N-1:0] opt_q,
  input  logic [N-1:0] lat_q,
  input  logic [N-1:0] pin_i,
  input  logic [N-1:0] fa_o,
  input  logic [N-1:0] fa_oe,
  input  logic [N-1:0] fb_o,
  input  logic [N-1:0] fb_oe,
  output logic [N-1:0] pin_o,
  output logic [N-1:0] pin_oe,
  output logic [N-1:0] fa_in,
  output logic [N-1:0] fb_in,
  output logic [N-1:0] alt_in
);
  for (genvar i = 0; i < N; i++) begin : g_pin
    logic is_gpo, is_fa, is_fb, is_alt;

    assign is_gpo = ~asg_q[i] &  dir_q[i];
    assign is_fa  =  asg_q[i] & ~dir_q[i];
    assign is_fb  =  asg_q[i] &  dir_q[i];
    assign is_alt =  opt_q[i] & ~dir_q[i];

    always_comb begin
      pin_o[i]  = 1'b0;
      pin_oe[i] = 1'b0;
      if (is_gpo) begin
        pin_o[i]  = lat_q[i];
        pin_oe[i] = 1'b1;
      end else if (is_fa) begin
        pin_o[i]  = fa_o[i];
        pin_oe[i] = fa_oe[i];
      end else if (is_fb) begin
        pin_o[i]  = fb_o[i];
        pin_oe[i] = fb_oe[i];
      end
    end

    assign fa_in[i]  = is_fa  ? pin_i[i] : TIE_A[i];
    assign fb_in[i]  = is_fb  ? pin_i[i] : TIE_B[i];
    assign alt_in[i] = is_alt ? pin_i[i] : TIE_S[i];
  end
endmodule

// File: rtl/pinmux_port.sv
module pinmux_port
  import pmx_pkg::*;
#(
  parameter int           N      = 12,
  parameter int           STAGES = 2,
  parameter logic [N-1:0] TIE_A  = 12'h0C3,
  parameter logic [N-1:0] TIE_B  = 12'hF00,
  parameter logic [N-1:0] TIE_S  = 12'h00F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [PMX_AW-1:0] bus_addr,
  input  logic [N-1:0]      bus_wdata,
  output logic [N-1:0]      bus_rdata,
  input  logic [N-1:0]      pin_i,
  output logic [N-1:0]      pin_o,
  output logic [N-1:0]      pin_oe,
  input  logic [N-1:0]      fa_o,
  input  logic [N-1:0]      fa_oe,
  input  logic [N-1:0]      fb_o,
  input  logic [N-1:0]      fb_oe,
  output logic [N-1:0]      fa_in,
  output logic [N-1:0]      fb_in,
  output logic [N-1:0]      alt_in,
  output logic              irq
);
  logic [N-1:0] asg_q, dir_q, opt_q, lat_q, edg_q, msk_q, evt_q;
  logic [N-1:0] pin_sync, edge_hit;

  pmx_sync_edge #(.N(N), .STAGES(STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_i    (pin_i),
    .edg_q    (edg_q),
    .pin_sync (pin_sync),
    .edge_hit (edge_hit)
  );

  pmx_regfile #(.N(N)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_sync  (pin_sync),
    .edge_hit  (edge_hit),
    .asg_q     (asg_q),
    .dir_q     (dir_q),
    .opt_q     (opt_q),
    .lat_q     (lat_q),
    .edg_q     (edg_q),
    .msk_q     (msk_q),
    .evt_q     (evt_q),
    .irq       (irq)
  );

  pmx_route #(.N(N), .TIE_A(TIE_A), .TIE_B(TIE_B), .TIE_S(TIE_S)) u_route (
    .asg_q  (asg_q),
    .dir_q  (dir_q),
    .opt_q  (opt_q),
    .lat_q  (lat_q),
    .pin_i  (pin_i),
    .fa_o   (fa_o),
    .fa_oe  (fa_oe),
    .fb_o   (fb_o),
    .fb_oe  (fb_oe),
    .pin_o  (pin_o),
    .pin_oe (pin_oe),
    .fa_in  (fa_in),
    .fb_in  (fb_in),
    .alt_in (alt_in)
  );
endmodule

// File: rtl/pmx_checker.sv
module pmx_checker
  import pmx_pkg::*;
#(
  parameter int N = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [PMX_AW-1:0] bus_addr,
  input logic [N-1:0]      bus_wdata,
  input logic [N-1:0]      pin_oe,
  input logic [N-1:0]      fa_oe,
  input logic [N-1:0]      asg_q,
  input logic [N-1:0]      dir_q,
  input logic [N-1:0]      msk_q,
  input logic [N-1:0]      evt_q,
  input logic              irq
);
  logic [N-1:0] clr_v;
  assign clr_v = (bus_sel && bus_wr && bus_addr == RA_EVENT) ? bus_wdata : '0;

  // R1: while reset is held, no pad is driven and no request is raised
  always @(posedge clk) begin
    if (rst_n === 1'b0) begin
      p_reset_quiet_r1: assert (pin_oe == '0 && irq == 1'b0);
    end
  end

  // R2: a GPIO output pin always has its pad enabled
  p_gpo_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((~asg_q & dir_q & ~pin_oe) == '0));

  // R4: function A pins take their enable from function A
  p_fa_enable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((asg_q & ~dir_q & (pin_oe ^ fa_oe)) == '0));

  // R8: an event bit only drops when 1 was written to it
  p_evt_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((($past(evt_q) & ~evt_q) & ~$past(clr_v)) == '0));

  // R9: the request matches the masked events
  p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq == (|(evt_q & msk_q))));
endmodule

bind pinmux_port pmx_checker #(.N(N)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pin_oe    (pin_oe),
  .fa_oe     (fa_oe),
  .asg_q     (asg_q),
  .dir_q     (dir_q),
  .msk_q     (msk_q),
  .evt_q     (evt_q),
  .irq       (irq)
);

// File: tb/test_pinmux_port.sv
`timescale 1ns/1ps
module test_pinmux_port;
  localparam int          N     = 12;
  localparam logic [11:0] TIE_A = 12'h0C3;
  localparam logic [11:0] TIE_B = 12'hF00;
  localparam logic [11:0] TIE_S = 12'h00F;
  localparam logic [2:0]  A_ASG = 3'd0, A_DIR = 3'd1, A_OPT = 3'd2, A_DATA = 3'd3,
                          A_EDGE = 3'd4, A_MASK = 3'd5, A_EVT = 3'd6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [N-1:0] bus_wdata = '0, bus_rdata;
  logic [N-1:0] pin_i = '0, pin_o, pin_oe;
  logic [N-1:0] fa_o = '0, fa_oe = '0, fb_o = '0, fb_oe = '0;
  logic [N-1:0] fa_in, fb_in, alt_in;
  logic irq;

  int total = 0;
  int bad = 0;
  logic [N-1:0] m_asg = '0, m_dir = '0, m_opt = '0, m_lat = '0;

  always #4 clk = ~clk;

  pinmux_port i_pinmux_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .fa_o(fa_o), .fa_oe(fa_oe), .fb_o(fb_o), .fb_oe(fb_oe),
    .fa_in(fa_in), .fb_in(fb_in), .alt_in(alt_in), .irq(irq)
  );

  function automatic logic [N-1:0] e_oe();
    return (~m_asg & m_dir) | (m_asg & ~m_dir & fa_oe) | (m_asg & m_dir & fb_oe);
  endfunction
  function automatic logic [N-1:0] e_out();
    return (~m_asg & m_dir & m_lat) | (m_asg & ~m_dir & fa_o) | (m_asg & m_dir & fb_o);
  endfunction
  function automatic logic [N-1:0] e_fa();
    return (m_asg & ~m_dir & pin_i) | (~(m_asg & ~m_dir) & TIE_A);
  endfunction
  function automatic logic [N-1:0] e_fb();
    return (m_asg & m_dir & pin_i) | (~(m_asg & m_dir) & TIE_B);
  endfunction
  function automatic logic [N-1:0] e_alt();
    return (m_opt & ~m_dir & pin_i) | (~(m_opt & ~m_dir) & TIE_S);
  endfunction

  task automatic chk(input string req, input string what, input logic [N-1:0] got, input logic [N-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%h expected=%h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [N-1:0] v);
    bus_addr = a; bus_sel = 1'b1; bus_wr = 1'b0;
    #1 v = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog: got=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    void'($urandom(32'd20240611));
    pin_i = 12'hA5A;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "pin_oe in reset", pin_oe, '0);
    chk("R1", "irq in reset", {11'd0, irq}, '0);
    rst_n = 1'b1;

    // R1 / R10: register state after reset with static mixed pins
    settle(10);
    rd(A_ASG, v);  chk("R1", "assign", v, '0);
    rd(A_DIR, v);  chk("R1", "direction", v, '0);
    rd(A_MASK, v); chk("R1", "mask", v, '0);
    rd(A_EVT, v);  chk("R10", "event after reset with high pins", v, '0);
    chk("R1", "pin_oe after reset", pin_oe, '0);

    // R3: exact two-edge latency of the data read path
    @(negedge clk);
    bus_addr = A_DATA; bus_sel = 1'b1; bus_wr = 1'b0;
    pin_i[2] = 1'b1;
    @(posedge clk); #1;
    chk("R3", "data after one edge", bus_rdata, 12'hA5A);
    @(posedge clk); #1;
    chk("R3", "data after two edges", bus_rdata, 12'hA5E);
    bus_sel = 1'b0;
    settle(3);
    wr(A_EVT, '1);

    // R7 / R9 / R8: any-edge event, masked request, write-one-to-clear
    wr(A_EDGE, '0);
    wr(A_MASK, '1);
    pin_i[0] = 1'b1;
    settle(4);
    rd(A_EVT, v); chk("R7", "rising edge any-edge mode", v, 12'h001);
    chk("R9", "irq with mask set", {11'd0, irq}, 12'h001);
    wr(A_EVT, 12'h001);
    #1;
    rd(A_EVT, v); chk("R8", "clear by writing one", v, '0);
    chk("R9", "irq after clear", {11'd0, irq}, '0);
    pin_i[0] = 1'b0;
    settle(4);
    rd(A_EVT, v); chk("R7", "falling edge any-edge mode", v, 12'h001);
    wr(A_EVT, 12'h000);
    #1;
    rd(A_EVT, v); chk("R8", "writing zero keeps event", v, 12'h001);
    wr(A_MASK, 12'hFFE);
    #1;
    chk("R9", "irq with mask cleared", {11'd0, irq}, '0);
    wr(A_MASK, 12'h001);
    #1;
    chk("R9", "irq with mask restored", {11'd0, irq}, 12'h001);
    wr(A_EVT, '1);

    // R7: falling-only mode on pin 1 (currently high)
    wr(A_EDGE, 12'h002);
    wr(A_MASK, '0);
    pin_i[1] = 1'b0;
    settle(4);
    rd(A_EVT, v); chk("R7", "falling edge in fall-only mode", v, 12'h002);
    wr(A_EVT, 12'h002);
    pin_i[1] = 1'b1;
    settle(4);
    rd(A_EVT, v); chk("R7", "rising edge in fall-only mode", v, '0);

    // R2: latch written while input, then exposed as output
    wr(A_DATA, 12'h5A5);
    m_lat = 12'h5A5;
    #1;
    chk("R2", "input pins not driven", pin_oe, '0);
    chk("R2", "input pins value held back", pin_o, '0);
    wr(A_DIR, '1);
    m_dir = '1;
    #1;
    chk("R2", "output pins show latch", pin_o, 12'h5A5);
    chk("R2", "output pins enabled", pin_oe, '1);
    settle(3);
    rd(A_DATA, v); chk("R3", "data read is pin not latch", v, pin_i);

    // Random routing, tie-offs and read-back
    for (int k = 0; k < 300; k++) begin
      logic [N-1:0] ra, rd_, ro, rl, re, rm;
      ra = N'($urandom); rd_ = N'($urandom); ro = N'($urandom);
      rl = N'($urandom); re = N'($urandom); rm = N'($urandom);
      if (k % 7 == 0) begin ra = '1; rd_ = '0; end
      if (k % 11 == 0) begin ra = '1; rd_ = '1; end
      wr(A_ASG, ra);  m_asg = ra;
      wr(A_DIR, rd_); m_dir = rd_;
      wr(A_OPT, ro);  m_opt = ro;
      wr(A_DATA, rl); m_lat = rl;
      wr(A_EDGE, re);
      wr(A_MASK, rm);
      fa_o = N'($urandom); fa_oe = N'($urandom);
      fb_o = N'($urandom); fb_oe = N'($urandom);
      pin_i = N'($urandom);
      settle(3);
      chk("R2", "random pin_o", pin_o, e_out());
      chk("R4", "random pin_oe", pin_oe, e_oe());
      chk("R5", "random fa_in", fa_in, e_fa());
      chk("R5", "random fb_in", fb_in, e_fb());
      chk("R6", "random alt_in", alt_in, e_alt());
      rd(A_DATA, v); chk("R3", "random data read", v, pin_i);
      rd(A_ASG, v);  chk("R11", "assign read-back", v, ra);
      rd(A_DIR, v);  chk("R11", "direction read-back", v, rd_);
      rd(A_OPT, v);  chk("R11", "option read-back", v, ro);
      rd(A_EDGE, v); chk("R11", "edge read-back", v, re);
      rd(A_MASK, v); chk("R11", "mask read-back", v, rm);
      begin
        logic [N-1:0] ev;
        rd(A_EVT, ev);
        chk("R9", "random irq", {11'd0, irq}, {11'd0, |(ev & rm)});
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule